// File: doc/BRIEF.md
# SDRAM Access and Refresh Command Sequencer

This block runs a memory device through normal operation once the power-up sequence is complete. On every clock edge it looks at a refresh request and an active-low request strobe. Each host request arrives from request queues as a 2-bit operation code, a row, a column and a bank. The block expands it into a timed series of device commands on the chip-select, row-strobe, column-strobe and write-enable pins, with the matching bank and address. A refresh request expands into a close-all-rows step followed by an auto refresh.

The block pops its request queues with a single pulse for each accepted request. It marks the end of every sequence with a done pulse and acknowledges each refresh. It also gives a separate data path read and write enable windows that line up with the column command. All device timing gaps are parameters counted in clock cycles.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is low, and after it until the first accepted request, the command pins show NOP (cs_n,ras_n,cas_n,we_n = 0111), bank and address are zero, and rd_en, wr_en, req_pop, seq_done and ref_ack are low.
- R2: While init_done is low, no command other than NOP is issued and neither req_pop nor ref_ack pulses, whatever the strobe and refresh inputs do.
- R3: When the sequencer is idle and samples ref_req high, it starts a refresh even if req_strobe_n is low at the same edge. The pending request is accepted only after the refresh has finished.
- R4: A refresh issues PRECHARGE (0010) with address bit AP_BIT set and bank 0 in the accepting cycle, pulsing ref_ack in that cycle. AUTO REFRESH (0001) follows T_RP cycles later with address and bank 0. seq_done pulses T_RFC cycles after that.
- R5: An accepted non-zero request issues ACTIVATE (0011) with req_row and req_bank in the accepting cycle. req_pop pulses high for exactly that one cycle.
- R6: T_RCD cycles after ACTIVATE, a column command is issued on the same bank. It is READ (0101) for codes 01 and 11 and WRITE (0100) for code 10. The column sits in the low address bits, and address bit AP_BIT is 1 only for code 11.
- R7: With L = CAS_LAT for reads and WR_LAT for writes, rd_en (reads) or wr_en (writes) is high exactly in the cycles L to L+BURST_CYC-1 after the column command. Only NOP is issued while either enable is high.
- R8: For codes 01 and 10, PRECHARGE (0010) with address 0 on the request's bank follows L+BURST_CYC cycles after the column command. seq_done pulses T_RP cycles after that.
- R9: For code 11 no explicit PRECHARGE is issued; seq_done pulses L+BURST_CYC+T_RP cycles after the column command.
- R10: Code 00 is consumed without any command: req_pop and seq_done pulse together in the accepting cycle, and the next edge may accept again.
- R11: Strobes and refresh requests are ignored while a sequence runs. The earliest next acceptance is at the clock edge that follows the seq_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done | input | 1 | High once device power-up is complete |
| ref_req | input | 1 | Refresh request, held until ref_ack |
| req_strobe_n | input | 1 | Active-low strobe, low while a request is queued |
| op_code | input | 2 | 00 none, 01 read, 10 write, 11 fast read |
| req_row | input | ROW_W | Row of the queued request |
| req_col | input | COL_W | Column of the queued request |
| req_bank | input | BANK_W | Bank of the queued request |
| sd_cs_n | output | 1 | Command chip select |
| sd_ras_n | output | 1 | Command row strobe |
| sd_cas_n | output | 1 | Command column strobe |
| sd_we_n | output | 1 | Command write enable |
| sd_bank | output | BANK_W | Device bank select |
| sd_addr | output | ROW_W | Device address bus |
| rd_en | output | 1 | Read data window for the data path |
| wr_en | output | 1 | Write data window for the data path |
| req_pop | output | 1 | One-cycle pop of the request queues |
| seq_done | output | 1 | One-cycle pulse on return to idle |
| ref_ack | output | 1 | One-cycle refresh acknowledge |

## Verification
The bench builds the sequencer with T_RCD=1, T_RP=2, T_RFC=5, CAS_LAT=3, WR_LAT=1 and BURST_CYC=2. These values are far below the defaults and reach two edges. T_RCD=1 puts the column command right after ACTIVATE, so the gap timer's zero load is exercised. WR_LAT=1 opens the write window in the cycle after the column command. The short gaps also let refresh-versus-strobe races, back-to-back requests with the strobe held low through a busy sequence, and the code-00 fast turnaround all occur many times in a short run.

// File: rtl/sdram_seq_pkg.sv
// Shared types for the command sequencer: pin-level command codes,
// request operation codes, decoded request flags and FSM states.
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001
    } sd_cmd_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_FREAD = 2'b11
    } op_code_e;

    typedef struct packed {
        logic valid;     // request issues device commands
        logic is_write;  // column command is WRITE
        logic fast;      // column command carries auto-precharge
    } op_dec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RCD,
        ST_XFER,
        ST_RP,
        ST_REF_RP,
        ST_RFC
    } seq_state_e;

    function automatic int gap_max(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_op_decode.sv
// Operation code decoder.
// Turns the 2-bit request code into access flags. Assumes the code is
// stable in the cycle the sequencer samples it. Purely combinational.
module seq_op_decode
    import sdram_seq_pkg::*;
(
    input  logic [1:0] code,
    output op_dec_t    dec
);

    // map each code onto valid / write / fast flags
    always_comb begin
        dec = '0;
        unique case (op_code_e'(code))
            OP_NONE:  dec = '0;
            OP_READ:  dec = '{valid: 1'b1, is_write: 1'b0, fast: 1'b0};
            OP_WRITE: dec = '{valid: 1'b1, is_write: 1'b1, fast: 1'b0};
            OP_FREAD: dec = '{valid: 1'b1, is_write: 1'b0, fast: 1'b1};
            default:  dec = '0;
        endcase
    end

endmodule

// File: rtl/seq_gap_timer.sv
// Down-counting gap timer.
// A load of value V makes 'expired' true after V further clock edges, so
// an FSM that loads gap-1 when issuing a command and acts on 'expired'
// issues its next command exactly 'gap' cycles later. Assumes loads only
// occur on the edge that issues a command.
module seq_gap_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // load on request, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/seq_data_window.sv
// Read/write data window generator.
// Started on the edge that issues a column command, it raises the read or
// write enable for BURST_CYC cycles beginning 'lat' cycles after that
// edge. Assumes a new start never arrives before the previous window ends.
module seq_data_window #(
    parameter int PH_W      = 4,
    parameter int BURST_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            is_write,
    input  logic [PH_W-1:0] lat,
    output logic            rd_en,
    output logic            wr_en
);

    localparam logic [PH_W-1:0] BURST_L = PH_W'(BURST_CYC);

    logic            busy;
    logic            en;
    logic            wr_q;
    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] lat_q;
    logic [PH_W-1:0] ph_nxt;

    assign ph_nxt = ph + 1'b1;

    // track cycles since the column command and open the window in range
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            en    <= 1'b0;
            wr_q  <= 1'b0;
            ph    <= '0;
            lat_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            ph    <= '0;
            wr_q  <= is_write;
            lat_q <= lat;
            en    <= (lat == '0);
        end else if (busy) begin
            if (ph_nxt >= lat_q + BURST_L) begin
                busy <= 1'b0;
                en   <= 1'b0;
            end else begin
                ph <= ph_nxt;
                en <= (ph_nxt >= lat_q);
            end
        end
    end

    assign rd_en = en & ~wr_q;
    assign wr_en = en & wr_q;

endmodule

// File: rtl/sdram_cmd_seq.sv
// SDRAM read/write/refresh command sequencer (top).
// After init_done it samples ref_req and req_strobe_n on every edge while
// idle. Refresh wins over a host request. A host request becomes
// ACTIVATE, READ/WRITE (auto-precharge for fast reads), optional PRECHARGE
// and a row-precharge wait. Refresh becomes PRECHARGE-all then AUTO
// REFRESH. All command outputs are registered. Assumes every timing
// parameter is at least 1 and COL_W <= AP_BIT < ROW_W.
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int BANK_W    = 3,
    parameter int AP_BIT    = 10,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 8,
    parameter int CAS_LAT   = 5,
    parameter int WR_LAT    = 4,
    parameter int BURST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              ref_req,
    input  logic              req_strobe_n,
    input  logic [1:0]        op_code,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [BANK_W-1:0] req_bank,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_bank,
    output logic [ROW_W-1:0]  sd_addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic              req_pop,
    output logic              seq_done,
    output logic              ref_ack
);

    localparam int MAX_LAT = gap_max(CAS_LAT, WR_LAT);
    localparam int LONGEST = gap_max(gap_max(T_RCD, T_RP),
                                     gap_max(T_RFC, MAX_LAT + BURST_CYC));
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam int PH_W    = $clog2(MAX_LAT + BURST_CYC + 2);

    localparam logic [CNT_W-1:0] RCD_M1   = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] RP_M1    = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] RFC_M1   = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] RXFER_M1 = CNT_W'(CAS_LAT + BURST_CYC - 1);
    localparam logic [CNT_W-1:0] WXFER_M1 = CNT_W'(WR_LAT + BURST_CYC - 1);
    localparam logic [PH_W-1:0]  RLAT     = PH_W'(CAS_LAT);
    localparam logic [PH_W-1:0]  WLAT     = PH_W'(WR_LAT);

    // registered state and outputs
    seq_state_e        st;
    sd_cmd_e           cmd_q;
    logic [BANK_W-1:0] ba_q;
    logic [ROW_W-1:0]  addr_q;
    logic              pop_q, done_q, ack_q;

    // captured request
    logic [BANK_W-1:0] bank_lat;
    logic [COL_W-1:0]  col_lat;
    logic              wr_lat;
    logic              fast_lat;

    // next-state values
    seq_state_e        st_n;
    sd_cmd_e           cmd_n;
    logic [BANK_W-1:0] ba_n;
    logic [ROW_W-1:0]  addr_n;
    logic              pop_n, done_n, ack_n;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              win_go;
    logic              capture;

    op_dec_t           dec;
    logic              tmr_zero;

    seq_op_decode u_decode (
        .code (op_code),
        .dec  (dec)
    );

    seq_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    seq_data_window #(.PH_W(PH_W), .BURST_CYC(BURST_CYC)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (win_go),
        .is_write (wr_lat),
        .lat      (wr_lat ? WLAT : RLAT),
        .rd_en    (rd_en),
        .wr_en    (wr_en)
    );

    // choose the next command, gap and state from the current phase
    always_comb begin
        st_n     = st;
        cmd_n    = CMD_NOP;
        ba_n     = '0;
        addr_n   = '0;
        pop_n    = 1'b0;
        done_n   = 1'b0;
        ack_n    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        win_go   = 1'b0;
        capture  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (init_done) begin
                    if (ref_req) begin
                        cmd_n          = CMD_PRE;
                        addr_n[AP_BIT] = 1'b1;
                        ack_n          = 1'b1;
                        tmr_load       = 1'b1;
                        tmr_val        = RP_M1;
                        st_n           = ST_REF_RP;
                    end else if (!req_strobe_n) begin
                        pop_n = 1'b1;
                        if (!dec.valid) begin
                            done_n = 1'b1;
                        end else begin
                            cmd_n    = CMD_ACT;
                            ba_n     = req_bank;
                            addr_n   = req_row;
                            capture  = 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = RCD_M1;
                            st_n     = ST_RCD;
                        end
                    end
                end
            end
            ST_RCD: begin
                if (tmr_zero) begin
                    cmd_n               = wr_lat ? CMD_WR : CMD_RD;
                    ba_n                = bank_lat;
                    addr_n[COL_W-1:0]   = col_lat;
                    addr_n[AP_BIT]      = fast_lat;
                    win_go              = 1'b1;
                    tmr_load            = 1'b1;
                    tmr_val             = wr_lat ? WXFER_M1 : RXFER_M1;
                    st_n                = ST_XFER;
                end
            end
            ST_XFER: begin
                if (tmr_zero) begin
                    if (!fast_lat) begin
                        cmd_n = CMD_PRE;
                        ba_n  = bank_lat;
                    end
                    tmr_load = 1'b1;
                    tmr_val  = RP_M1;
                    st_n     = ST_RP;
                end
            end
            ST_RP: begin
                if (tmr_zero) begin
                    done_n = 1'b1;
                    st_n   = ST_IDLE;
                end
            end
            ST_REF_RP: begin
                if (tmr_zero) begin
                    cmd_n    = CMD_REF;
                    tmr_load = 1'b1;
                    tmr_val  = RFC_M1;
                    st_n     = ST_RFC;
                end
            end
            ST_RFC: begin
                if (tmr_zero) begin
                    done_n = 1'b1;
                    st_n   = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // register state, command pins and pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
            pop_q  <= 1'b0;
            done_q <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            st     <= st_n;
            cmd_q  <= cmd_n;
            ba_q   <= ba_n;
            addr_q <= addr_n;
            pop_q  <= pop_n;
            done_q <= done_n;
            ack_q  <= ack_n;
        end
    end

    // hold the accepted request for the rest of its sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_lat <= '0;
            col_lat  <= '0;
            wr_lat   <= 1'b0;
            fast_lat <= 1'b0;
        end else if (capture) begin
            bank_lat <= req_bank;
            col_lat  <= req_col;
            wr_lat   <= dec.is_write;
            fast_lat <= dec.fast;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_bank  = ba_q;
    assign sd_addr  = addr_q;
    assign req_pop  = pop_q;
    assign seq_done = done_q;
    assign ref_ack  = ack_q;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
// Property checker for the command sequencer, bound to every instance.
// Watches only the block's ports; gap checks use saturating counters.
module sdram_cmd_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       init_done,
    input logic [3:0] cmd,
    input logic       ap_bit,
    input logic       rd_en,
    input logic       wr_en,
    input logic       req_pop,
    input logic       seq_done,
    input logic       ref_ack
);

    logic [15:0] since_act;
    logic [15:0] since_pre_all;
    logic        is_col;

    assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

    // cycles since the last ACTIVATE / precharge-all seen on the pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act     <= 16'hFFFF;
            since_pre_all <= 16'hFFFF;
        end else begin
            if (cmd == CMD_ACT)
                since_act <= 16'd1;
            else if (since_act != 16'hFFFF)
                since_act <= since_act + 16'd1;
            if (cmd == CMD_PRE && ap_bit)
                since_pre_all <= 16'd1;
            else if (since_pre_all != 16'hFFFF)
                since_pre_all <= since_pre_all + 16'd1;
        end
    end

    assert_no_accept_uninit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |=> (!req_pop && !ref_ack));

    assert_refresh_excludes_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> !req_pop);

    assert_refresh_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> (since_pre_all == 16'(T_RP)));

    assert_activate_pops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> req_pop);

    assert_column_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_act == 16'(T_RCD)));

    assert_window_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> (cmd == CMD_NOP));

    assert_pop_without_act_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_pop |-> ((cmd == CMD_ACT) || seq_done));

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
    .T_RCD (T_RCD),
    .T_RP  (T_RP)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done),
    .cmd       ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .ap_bit    (sd_addr[AP_BIT]),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .req_pop   (req_pop),
    .seq_done  (seq_done),
    .ref_ack   (ref_ack)
);

// File: tb/test_sdram_cmd_seq.sv
`timescale 1ns/1ps
// Bench: a behavioural model schedules the expected pin values of every
// future cycle when a request is accepted; outputs are compared each cycle.
module test_sdram_cmd_seq;

    localparam int RW = 13, CW = 10, BW = 3, AP = 10;
    localparam int TRCD = 1, TRP = 2, TRFC = 5, CL = 3, WL = 1, BL = 2;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_done = 1'b0;
    logic ref_req = 1'b0;
    logic req_strobe_n = 1'b1;
    logic [1:0] op_code = 2'b00;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [BW-1:0] req_bank = '0;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BW-1:0] sd_bank;
    logic [RW-1:0] sd_addr;
    logic rd_en, wr_en, req_pop, seq_done, ref_ack;

    int checks = 0;
    int errors = 0;
    int n = 0;
    int free_at = 0;
    int wd = 0;
    string phase_tag = "R1";

    always #2.5 clk = ~clk;

    sdram_cmd_seq #(
        .ROW_W(RW), .COL_W(CW), .BANK_W(BW), .AP_BIT(AP),
        .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC),
        .CAS_LAT(CL), .WR_LAT(WL), .BURST_CYC(BL)
    ) i_sdram_cmd_seq (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .ref_req(ref_req),
        .req_strobe_n(req_strobe_n), .op_code(op_code), .req_row(req_row),
        .req_col(req_col), .req_bank(req_bank),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_bank(sd_bank), .sd_addr(sd_addr), .rd_en(rd_en), .wr_en(wr_en),
        .req_pop(req_pop), .seq_done(seq_done), .ref_ack(ref_ack)
    );

    typedef struct packed {
        logic [3:0]    cmd;
        logic [BW-1:0] ba;
        logic [RW-1:0] a;
        logic rd, wr, pop, done, ack;
    } exp_t;

    exp_t sched [int];

    function automatic exp_t idle_exp();
        exp_t e;
        e = '0;
        e.cmd = C_NOP;
        return e;
    endfunction

    function automatic exp_t get_exp(int c);
        if (sched.exists(c)) return sched[c];
        return idle_exp();
    endfunction

    function automatic void put_cmd(int c, logic [3:0] k, logic [BW-1:0] b, logic [RW-1:0] a);
        exp_t e;
        e = get_exp(c);
        e.cmd = k; e.ba = b; e.a = a;
        sched[c] = e;
    endfunction

    function automatic string tag_for(exp_t e, string dflt);
        if (e.cmd == C_ACT) return "R5";
        if (e.cmd == C_RD || e.cmd == C_WR) return "R6";
        if (e.cmd == C_REF || e.ack) return "R4";
        if (e.cmd == C_PRE) return "R8";
        if (e.rd || e.wr) return "R7";
        if (e.pop && e.done) return "R10";
        return dflt;
    endfunction

    // reference model: on acceptance, schedule all future expected values
    always @(posedge clk) begin
        if (!rst_n) begin
            n = 0;
            free_at = 0;
        end else begin
            n = n + 1;
            if (init_done && n >= free_at) begin
                if (ref_req) begin
                    exp_t e;
                    logic [RW-1:0] aa;
                    aa = '0; aa[AP] = 1'b1;
                    put_cmd(n, C_PRE, '0, aa);
                    e = get_exp(n); e.ack = 1'b1; sched[n] = e;
                    put_cmd(n + TRP, C_REF, '0, '0);
                    e = get_exp(n + TRP + TRFC); e.done = 1'b1; sched[n + TRP + TRFC] = e;
                    free_at = n + TRP + TRFC + 1;
                end else if (!req_strobe_n) begin
                    exp_t e;
                    e = get_exp(n); e.pop = 1'b1; sched[n] = e;
                    if (op_code == 2'b00) begin
                        e = get_exp(n); e.done = 1'b1; sched[n] = e;
                        free_at = n + 1;
                    end else begin
                        int c, lat, p;
                        logic isw, fst;
                        logic [RW-1:0] ca;
                        isw = (op_code == 2'b10);
                        fst = (op_code == 2'b11);
                        lat = isw ? WL : CL;
                        put_cmd(n, C_ACT, req_bank, req_row);
                        c = n + TRCD;
                        ca = '0; ca[CW-1:0] = req_col; ca[AP] = fst;
                        put_cmd(c, isw ? C_WR : C_RD, req_bank, ca);
                        for (int k = lat; k < lat + BL; k++) begin
                            e = get_exp(c + k);
                            if (isw) e.wr = 1'b1; else e.rd = 1'b1;
                            sched[c + k] = e;
                        end
                        p = c + lat + BL;
                        if (!fst) put_cmd(p, C_PRE, req_bank, '0);
                        e = get_exp(p + TRP); e.done = 1'b1; sched[p + TRP] = e;
                        free_at = p + TRP + 1;
                    end
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        exp_t e;
        string tg;
        if (n == 0) begin
            e = idle_exp(); tg = "R1";
        end else begin
            e = get_exp(n); tg = tag_for(e, phase_tag);
        end
        checks++;
        if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} !== e.cmd || sd_bank !== e.ba ||
            sd_addr !== e.a || rd_en !== e.rd || wr_en !== e.wr || req_pop !== e.pop ||
            seq_done !== e.done || ref_ack !== e.ack) begin
            errors++;
            $display("FAIL %s cycle %0d: got cmd=%b ba=%0d a=%h rd=%b wr=%b pop=%b done=%b ack=%b expected cmd=%b ba=%0d a=%h rd=%b wr=%b pop=%b done=%b ack=%b",
                tg, n, {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, sd_bank, sd_addr, rd_en, wr_en,
                req_pop, seq_done, ref_ack, e.cmd, e.ba, e.a, e.rd, e.wr, e.pop, e.done, e.ack);
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog: a hung run is a failed check
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog: cycles=%0d expected below 20000", wd);
            finish_run();
        end
    end

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wait_pop();
        @(negedge clk);
        while (req_pop !== 1'b1) @(negedge clk);
    endtask

    task automatic wait_ack();
        @(negedge clk);
        while (ref_ack !== 1'b1) @(negedge clk);
    endtask

    task automatic set_req(logic [1:0] op, int row, int col, int bank);
        op_code  = op;
        req_row  = RW'(row);
        req_col  = CW'(col);
        req_bank = BW'(bank);
        req_strobe_n = 1'b0;
    endtask

    task automatic one_req(logic [1:0] op, int row, int col, int bank);
        set_req(op, row, col, bank);
        wait_pop();
        req_strobe_n = 1'b1;
        idle(20);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(3);

        // R2: strobe and refresh held while not initialised
        phase_tag = "R2";
        set_req(2'b01, 5, 6, 1);
        ref_req = 1'b1;
        idle(10);
        req_strobe_n = 1'b1;
        ref_req = 1'b0;
        idle(2);

        // R3: refresh and strobe raised at the same edge
        phase_tag = "R3";
        init_done = 1'b1;
        ref_req = 1'b1;
        set_req(2'b01, 12'h3A5, 10'h155, 6);
        wait_ack();
        ref_req = 1'b0;
        wait_pop();
        req_strobe_n = 1'b1;
        idle(20);

        // R8: normal write, normal read
        phase_tag = "R8";
        one_req(2'b10, 13'h1FFF, 10'h3FF, 7);
        one_req(2'b01, 13'h0001, 10'h001, 0);

        // R9: fast read with auto-precharge
        phase_tag = "R9";
        one_req(2'b11, 13'h0AAA, 10'h2AA, 3);

        // R10: empty code then a read with the strobe kept low
        phase_tag = "R10";
        set_req(2'b00, 1, 2, 3);
        wait_pop();
        set_req(2'b01, 13'h0123, 10'h045, 2);
        wait_pop();
        req_strobe_n = 1'b1;
        idle(20);

        // R11: strobe held low and refresh raised while busy
        phase_tag = "R11";
        set_req(2'b10, 13'h0777, 10'h0F0, 5);
        wait_pop();
        set_req(2'b11, 13'h0666, 10'h00F, 4);
        idle(2);
        ref_req = 1'b1;
        wait_ack();
        ref_req = 1'b0;
        wait_pop();
        req_strobe_n = 1'b1;
        idle(20);

        // R6: mixed pattern sweep, back-to-back with strobe low
        phase_tag = "R6";
        for (int i = 0; i < 12; i++) begin
            set_req(2'(i % 4), i * 611 + 3, i * 83 + 1, i % 8);
            wait_pop();
        end
        req_strobe_n = 1'b1;
        idle(25);

        finish_run();
    end

endmodule